// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This unit combines two packed mask words bit by bit using any of the sixteen Boolean functions of two inputs. A 4-bit truth table picks the function. Every bit position reads its result from that table, so clear, set, copy, invert and all the usual gates share one selection path. No gate is specific to an opcode.

The caller can supply the table directly in raw mode. It can also name a common operation through a 4-bit operation select, which a small decoder turns into the matching table. The result is captured in a register one clock after a valid input, together with a valid flag. The block has no state machine: its only state is the output register, which either loads, holds or resets.

Top module: `ttlu`

## Requirements
- R1: For every bit i, the result bit equals tt[{src1[i], src2[i]}], where tt is the effective 4-bit truth table and src1 supplies the high index bit. So tt[3] applies to (1,1), tt[2] to (1,0), tt[1] to (0,1) and tt[0] to (0,0).
- R2: A table of 4'b0000 yields all zeros and 4'b1111 yields all ones, whatever the operand values.
- R3: When raw_mode is 1, the effective table is raw_code and op_sel has no effect.
- R4: When raw_mode is 0, op_sel selects a table as follows. 0 AND gives 4'b1000. 1 OR gives 4'b1110. 2 XOR gives 4'b0110. 3 ANDN (src1 & ~src2) gives 4'b0100. 4 ORN (src1 | ~src2) gives 4'b1101. 5 XORN (src1 ^ ~src2) gives 4'b1001. 6 NAND gives 4'b0111. 7 NOR gives 4'b0001. 8 CLR gives 4'b0000. 9 SET gives 4'b1111. 10 NOT1 (~src1) gives 4'b0011. 11 CPY1 (src1) gives 4'b1100.
- R5: When raw_mode is 0, op_sel values 12 to 15 behave as CLR and produce an all-zero result.
- R6: If in_valid is 1 at a rising edge, out_valid is 1 after that edge and result holds the function of that cycle's inputs. If in_valid is 0 at a rising edge, out_valid is 0 after that edge.
- R7: While in_valid is 0, result keeps its previous value whatever the operands and selects do.
- R8: A synchronous active-high rst clears result and out_valid at the next edge, and it overrides an in_valid that is high in the same cycle.
- R9: Table 4'b1100 copies src1, 4'b1010 copies src2, 4'b0011 inverts src1 and 4'b0101 inverts src2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| raw_mode | input | 1 | 1: use raw_code as the truth table; 0: decode op_sel |
| op_sel | input | 4 | Named operation select (see R4) |
| raw_code | input | 4 | User-supplied truth table |
| src1 | input | XLEN | First mask operand (high table index bit) |
| src2 | input | XLEN | Second mask operand (low table index bit) |
| out_valid | output | 1 | Result register holds a new value |
| result | output | XLEN | Registered bit-wise result |

## Verification
Two actions can fall in the same cycle, and the bench provokes both pairs. In the first, a reset and a valid input meet in one cycle. The bench drives rst and in_valid together with a SET table, and it passes only if the next sample shows a zero result and a low out_valid. In the second, the raw table and a named operation select disagree. The bench drives raw_mode with an XOR table while op_sel names AND, and it compares the result against the XOR reference. All sixteen tables are then compared against a reference computed bit by bit on fixed corner operands and on random ones.

// File: rtl/ttlu_pkg.sv
package ttlu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_ANDN = 4'd3,
        OP_ORN  = 4'd4,
        OP_XORN = 4'd5,
        OP_NAND = 4'd6,
        OP_NOR  = 4'd7,
        OP_CLR  = 4'd8,
        OP_SET  = 4'd9,
        OP_NOT1 = 4'd10,
        OP_CPY1 = 4'd11
    } op_e;

    localparam int TT_W = 4;

    // Table bit k gives the result for index k = {src1_bit, src2_bit}
    localparam logic [TT_W-1:0] TT_AND  = 4'b1000;
    localparam logic [TT_W-1:0] TT_OR   = 4'b1110;
    localparam logic [TT_W-1:0] TT_XOR  = 4'b0110;
    localparam logic [TT_W-1:0] TT_ANDN = 4'b0100;
    localparam logic [TT_W-1:0] TT_ORN  = 4'b1101;
    localparam logic [TT_W-1:0] TT_XNOR = 4'b1001;
    localparam logic [TT_W-1:0] TT_NAND = 4'b0111;
    localparam logic [TT_W-1:0] TT_NOR  = 4'b0001;
    localparam logic [TT_W-1:0] TT_CLR  = 4'b0000;
    localparam logic [TT_W-1:0] TT_SET  = 4'b1111;
    localparam logic [TT_W-1:0] TT_NOT1 = 4'b0011;
    localparam logic [TT_W-1:0] TT_CPY1 = 4'b1100;

endpackage

// File: rtl/ttlu_op_decode.sv
module ttlu_op_decode
    import ttlu_pkg::*;
(
    input  logic            raw_mode,
    input  logic [3:0]      op_sel,
    input  logic [TT_W-1:0] raw_code,
    output logic [TT_W-1:0] code
);

    logic [TT_W-1:0] named_code;

    always_comb begin
        unique case (op_e'(op_sel))
            OP_AND:  named_code = TT_AND;
            OP_OR:   named_code = TT_OR;
            OP_XOR:  named_code = TT_XOR;
            OP_ANDN: named_code = TT_ANDN;
            OP_ORN:  named_code = TT_ORN;
            OP_XORN: named_code = TT_XNOR;
            OP_NAND: named_code = TT_NAND;
            OP_NOR:  named_code = TT_NOR;
            OP_CLR:  named_code = TT_CLR;
            OP_SET:  named_code = TT_SET;
            OP_NOT1: named_code = TT_NOT1;
            OP_CPY1: named_code = TT_CPY1;
            default: named_code = TT_CLR;   // unassigned selects clear (R5)
        endcase
    end

    // Raw table takes priority over the named select (R3)
    assign code = raw_mode ? raw_code : named_code;

endmodule

// File: rtl/ttlu_lut_array.sv
module ttlu_lut_array
    import ttlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [TT_W-1:0] code,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    // One 4:1 selector per bit, indexed by {a, b} (R1)
    for (genvar gi = 0; gi < XLEN; gi++) begin : g_bit
        assign y[gi] = code[{a[gi], b[gi]}];
    end

endmodule

// File: rtl/ttlu_out_stage.sv
module ttlu_out_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         valid,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/ttlu.sv
module ttlu
    import ttlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            raw_mode,
    input  logic [3:0]      op_sel,
    input  logic [3:0]      raw_code,
    input  logic [XLEN-1:0] src1,
    input  logic [XLEN-1:0] src2,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);

    logic [TT_W-1:0] eff_code;
    logic [XLEN-1:0] comb_res;

    ttlu_op_decode u_dec (
        .raw_mode (raw_mode),
        .op_sel   (op_sel),
        .raw_code (raw_code),
        .code     (eff_code)
    );

    ttlu_lut_array #(.XLEN(XLEN)) u_lut (
        .code (eff_code),
        .a    (src1),
        .b    (src2),
        .y    (comb_res)
    );

    ttlu_out_stage #(.W(XLEN)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d     (comb_res),
        .valid (out_valid),
        .q     (result)
    );

    // R6: valid flag follows the input valid by one cycle
    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drops_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: constant tables ignore the operands
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_code == TT_CLR) |=> (result == '0));
    p_set_ones_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_code == TT_SET) |=> (result == '1));

    // R9: copy table reproduces the first operand
    p_copy_src1_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_code == TT_CPY1) |=> (result == $past(src1)));

    // R7: result holds while no input is valid
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8: reset clears the output register
    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

endmodule

// File: tb/ttlu_tb.sv
module ttlu_tb;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            raw_mode;
    logic [3:0]      op_sel;
    logic [3:0]      raw_code;
    logic [XLEN-1:0] src1;
    logic [XLEN-1:0] src2;
    logic            out_valid;
    logic [XLEN-1:0] result;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    ttlu #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .raw_mode(raw_mode),
        .op_sel(op_sel), .raw_code(raw_code), .src1(src1), .src2(src2),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [XLEN-1:0] ref_tt(input logic [3:0] c,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = c[{a[i], b[i]}];
        return r;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one valid operation at a falling edge; sample after the next rising edge
    task automatic apply(input logic rm, input logic [3:0] op, input logic [3:0] rc,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; raw_mode = rm; op_sel = op; raw_code = rc;
        src1 = a; src2 = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset out_valid", {63'd0, out_valid}, '0);
        chk("R8 reset result", result, '0);
    endtask

    task automatic t_all_codes;
        logic [XLEN-1:0] pa [4];
        logic [XLEN-1:0] pb [4];
        pa[0] = 64'hF0F0_CCCC_AAAA_0000; pb[0] = 64'hFF00_F0F0_CCCC_AAAA;
        pa[1] = '0;                      pb[1] = '1;
        pa[2] = 64'h1234_5678_9ABC_DEF0; pb[2] = 64'h0FED_CBA9_8765_4321;
        pa[3] = {$urandom, $urandom};    pb[3] = {$urandom, $urandom};
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                apply(1'b1, 4'd0, c[3:0], pa[p], pb[p]);
                chk("R1 table lookup", result, ref_tt(c[3:0], pa[p], pb[p]));
            end
        end
        for (int k = 0; k < 8; k++) begin
            logic [XLEN-1:0] ra, rb;
            ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
            apply(1'b1, 4'd0, 4'b0000, ra, rb);
            chk("R2 clear", result, '0);
            apply(1'b1, 4'd0, 4'b1111, ra, rb);
            chk("R2 set", result, '1);
        end
    endtask

    task automatic t_copy_invert;
        logic [XLEN-1:0] ra, rb;
        ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
        apply(1'b1, 4'd0, 4'b1100, ra, rb); chk("R9 copy src1", result, ra);
        apply(1'b1, 4'd0, 4'b1010, ra, rb); chk("R9 copy src2", result, rb);
        apply(1'b1, 4'd0, 4'b0011, ra, rb); chk("R9 invert src1", result, ~ra);
        apply(1'b1, 4'd0, 4'b0101, ra, rb); chk("R9 invert src2", result, ~rb);
    endtask

    task automatic t_named_ops;
        logic [XLEN-1:0] ra, rb;
        logic [XLEN-1:0] exp [12];
        for (int r = 0; r < 3; r++) begin
            ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
            exp[0] = ra & rb;   exp[1] = ra | rb;   exp[2] = ra ^ rb;
            exp[3] = ra & ~rb;  exp[4] = ra | ~rb;  exp[5] = ra ^ ~rb;
            exp[6] = ~(ra & rb); exp[7] = ~(ra | rb); exp[8] = '0;
            exp[9] = '1;        exp[10] = ~ra;      exp[11] = ra;
            for (int o = 0; o < 12; o++) begin
                apply(1'b0, o[3:0], 4'b1111, ra, rb);
                chk("R4 named op", result, exp[o]);
            end
        end
    endtask

    task automatic t_unused_ops;
        for (int o = 12; o < 16; o++) begin
            apply(1'b0, o[3:0], 4'b1111, '1, '1);
            chk("R5 unused select clears", result, '0);
        end
    endtask

    task automatic t_raw_priority;
        logic [XLEN-1:0] ra, rb;
        ra = 64'hDEAD_BEEF_0123_4567; rb = 64'hFFFF_0000_FF00_F0F0;
        apply(1'b1, 4'd0, 4'b0110, ra, rb);
        chk("R3 raw overrides op_sel", result, ra ^ rb);
    endtask

    task automatic t_valid_hold;
        logic [XLEN-1:0] ra;
        ra = 64'hA5A5_5A5A_0F0F_F0F0;
        @(negedge clk);
        in_valid = 1'b1; raw_mode = 1'b1; raw_code = 4'b1100; src1 = ra; src2 = '0;
        @(negedge clk);
        chk("R6 out_valid high", {63'd0, out_valid}, 64'd1);
        chk("R6 result captured", result, ra);
        in_valid = 1'b0; raw_code = 4'b1111; src1 = '0;
        @(negedge clk);
        chk("R6 out_valid low", {63'd0, out_valid}, '0);
        chk("R7 result held", result, ra);
        @(negedge clk);
        chk("R7 result still held", result, ra);
    endtask

    task automatic t_reset_collision;
        @(negedge clk);
        in_valid = 1'b1; raw_mode = 1'b1; raw_code = 4'b1111; rst = 1'b1;
        @(negedge clk);
        chk("R8 reset beats valid: out_valid", {63'd0, out_valid}, '0);
        chk("R8 reset beats valid: result", result, '0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; raw_mode = 1'b0; op_sel = '0;
        raw_code = '0; src1 = '0; src2 = '0;
        t_reset();
        t_all_codes();
        t_copy_invert();
        t_named_ops();
        t_unused_ops();
        t_raw_priority();
        t_valid_hold();
        t_reset_collision();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule